// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block drives a processor reset line from two sources. The first is a digitised supply monitor: while the supply is flagged as below threshold, or while the system runs from its backup source, reset is held asserted. Once the supply is good again, reset is kept asserted for a fixed hold time so that the regulator and the processor can settle. The second source is a watchdog that watches a strobe line driven by software. If the strobe fails to change level within the watchdog period, a reset pulse of the same fixed hold time is issued.

The strobe passes through a two-flop synchroniser, and either a rising or a falling edge restarts the watchdog period. A strobe that is stuck high or low produces a train of reset pulses, one after every watchdog period. The watchdog is switched off by a low enable input, which stands in for a floated strobe pin, and also while in backup mode. Both timings are parameters given in clock cycles. The outputs are an active-low reset and its exact active-high complement.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `supply_low` is 1, `reset_n` is 0 in the same cycle, without waiting for a clock edge, and stays 0 for as long as the flag is held.
- R2: After `supply_low` returns to 0, `reset_n` stays 0 for exactly HOLD_CYCLES rising edges and is 1 after the HOLD_CYCLES-th edge.
- R3: A rising or a falling edge on `wd_strobe` restarts the watchdog period. The strobe passes two synchroniser flops and one edge register, so with the strobe then held steady the watchdog pulse begins after the (WD_CYCLES+3)-th edge that follows the change.
- R4: With `wd_enable` at 1, the strobe steady and reset released, `reset_n` stays 1 for WD_CYCLES-1 edges after release and falls after the WD_CYCLES-th edge.
- R5: A watchdog reset pulse holds `reset_n` at 0 for exactly HOLD_CYCLES cycles.
- R6: While the strobe stays stuck, pulses repeat with `reset_n` high for WD_CYCLES cycles and low for HOLD_CYCLES cycles.
- R7: With `wd_enable` at 0, no watchdog pulse is issued however long the strobe is steady, and the watchdog count is cleared. After re-enabling, a full WD_CYCLES period runs before a pulse.
- R8: `backup_mode` at 1 forces `reset_n` to 0 in the same cycle and stops and clears the watchdog. After it returns to 0, the HOLD_CYCLES hold of R2 applies, followed by a full watchdog period.
- R9: `reset_p` always equals the inverse of `reset_n`.
- R10: The synchronous reset `rst` asserts the reset outputs at the next edge. After `rst` is released, the HOLD_CYCLES hold of R2 applies.
- R11: The watchdog count is cleared and held while reset is asserted for any cause. It starts counting from zero only after reset releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_low | input | 1 | Supply below threshold flag, 1 = bad |
| backup_mode | input | 1 | Running from backup source, 1 = backup |
| wd_strobe | input | 1 | Watchdog strobe from software, asynchronous |
| wd_enable | input | 1 | 1 = watchdog active, 0 = strobe treated as floating |
| reset_n | output | 1 | Active-low processor reset |
| reset_p | output | 1 | Active-high processor reset, inverse of reset_n |

## Verification
The supply and backup flags reach `reset_n` through logic only, so their effect is sampled 2 ns after the input changes, with no clock edge in between. Every other result is counted in rising edges from a negedge at which the stimulus was applied. The release comes after HOLD_CYCLES edges. A watchdog pulse comes WD_CYCLES edges after release, or WD_CYCLES+3 edges after a strobe change, the extra three being the synchroniser and edge register. Each of these is checked on both sides of its edge: one sample at the last edge where the old value is due and one at the first edge where the new value is due. All samples are taken at the falling clock edge, so a pulse that is one cycle too long or too short, or a latency that is off by one stage, shows up as a failed check.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Control bundle handed from the top to the watchdog counter.
    typedef struct packed {
        logic run;   // counting allowed: enabled, not in backup, reset released
        logic kick;  // a synchronised strobe edge was seen this cycle
    } wd_ctl_t;

    // Counter width able to hold values 0 .. limit-1 (at least 1 bit).
    function automatic int cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/supv_strobe_sync.sv
module supv_strobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    output logic toggled
);
    // pipe[0..SYNC_STAGES-1] synchronise; pipe[SYNC_STAGES] holds the previous level
    logic [SYNC_STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[SYNC_STAGES-1:0], strobe_in};
    end

    assign toggled = pipe[SYNC_STAGES-1] ^ pipe[SYNC_STAGES];

    // R3: an edge seen now is reported by the edge register on the next cycle
    assert_edge_tracks_R3: assert property (@(posedge clk) disable iff (rst)
        toggled |=> (pipe[SYNC_STAGES] == $past(pipe[SYNC_STAGES-1])));

endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
    import supv_pkg::*;
#(
    parameter int unsigned WD_CYCLES = 80_000_000
) (
    input  logic    clk,
    input  logic    rst,
    input  wd_ctl_t ctl,
    output logic    fire
);
    localparam int          CW   = cnt_bits(WD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign fire = ctl.run && !ctl.kick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !ctl.run || ctl.kick || fire) cnt <= '0;
        else                                     cnt <= cnt + 1'b1;
    end

    // R4: the count never runs past the period
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R7 / R11: an idle watchdog (disabled, backup or in reset) restarts from zero
    assert_idle_clears_R11: assert property (@(posedge clk) disable iff (rst)
        !ctl.run |=> (cnt == '0));

    // R3: a strobe edge restarts the period
    assert_kick_restarts_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.run && ctl.kick) |=> (cnt == '0));

endmodule

// File: rtl/supv_hold.sv
module supv_hold
    import supv_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic force_low,
    input  logic wd_fire,
    output logic hold_active
);
    localparam int            HW   = cnt_bits(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] FULL = HW'(HOLD_CYCLES);

    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || force_low || wd_fire) cnt <= FULL;
        else if (cnt != '0)              cnt <= cnt - 1'b1;
    end

    assign hold_active = (cnt != '0);

    // R1: a bad supply or backup mode reloads the full hold time
    assert_force_reload_R1: assert property (@(posedge clk) disable iff (rst)
        force_low |=> (cnt == FULL));

    // R2: once the cause is gone the hold drains by one per cycle
    assert_countdown_R2: assert property (@(posedge clk) disable iff (rst)
        (hold_active && !force_low && !wd_fire) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
    import supv_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 10_000_000,
    parameter int unsigned WD_CYCLES   = 80_000_000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_low,
    input  logic backup_mode,
    input  logic wd_strobe,
    input  logic wd_enable,
    output logic reset_n,
    output logic reset_p
);
    logic    strobe_edge;
    logic    hold_active;
    logic    wd_fire;
    logic    force_low;
    logic    asserted;
    wd_ctl_t wd_ctl;

    supv_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (wd_strobe),
        .toggled   (strobe_edge)
    );

    assign force_low = supply_low | backup_mode;
    assign asserted  = force_low | hold_active;

    always_comb begin
        wd_ctl.run  = wd_enable && !backup_mode && !asserted;
        wd_ctl.kick = strobe_edge;
    end

    supv_wdog #(.WD_CYCLES(WD_CYCLES)) u_wdog (
        .clk  (clk),
        .rst  (rst),
        .ctl  (wd_ctl),
        .fire (wd_fire)
    );

    supv_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .force_low   (force_low),
        .wd_fire     (wd_fire),
        .hold_active (hold_active)
    );

    assign reset_n = ~asserted;
    assign reset_p = asserted;

    // R5: a watchdog expiry is followed by an asserted reset
    assert_fire_pulses_R5: assert property (@(posedge clk) disable iff (rst)
        wd_fire |=> !reset_n);

    // R8: no watchdog expiry while running from backup
    assert_backup_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        backup_mode |-> !wd_fire);

    // R7: a disabled watchdog never expires
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !wd_enable |-> !wd_fire);

endmodule

// File: tb/sim_supv_reset_ctrl.sv
module sim_supv_reset_ctrl;
    localparam int H  = 8;
    localparam int WD = 20;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic rst = 1'b1;
    logic supply_low = 1'b0, backup_mode = 1'b0, wd_strobe = 1'b0, wd_enable = 1'b0;
    logic reset_n, reset_p;
    int   checks = 0;
    int   fails  = 0;

    supv_reset_ctrl #(.HOLD_CYCLES(H), .WD_CYCLES(WD)) u0 (
        .clk(clk), .rst(rst), .supply_low(supply_low), .backup_mode(backup_mode),
        .wd_strobe(wd_strobe), .wd_enable(wd_enable), .reset_n(reset_n), .reset_p(reset_p)
    );

    typedef struct packed {
        logic sl; logic bk; logic en; logic sb;
        int   n;       // rising edges to wait; 0 = sample 2 ns after drive
        logic exp_n;   // expected reset_n
        int   req;
    } step_t;

    localparam int NS = 35;
    localparam step_t STEPS [NS] = '{
        '{1'b0,1'b0,1'b0,1'b0, H-1,  1'b0, 2},   // R2 power-on hold
        '{1'b0,1'b0,1'b0,1'b0, 1,    1'b1, 2},
        '{1'b1,1'b0,1'b0,1'b0, 0,    1'b0, 1},   // R1 immediate
        '{1'b1,1'b0,1'b0,1'b0, 50,   1'b0, 1},   // R1 held
        '{1'b0,1'b0,1'b0,1'b0, H-1,  1'b0, 2},   // R2 exact timeout
        '{1'b0,1'b0,1'b0,1'b0, 1,    1'b1, 2},
        '{1'b0,1'b0,1'b1,1'b0, WD-1, 1'b1, 4},   // R4 stuck strobe
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b0, 4},
        '{1'b0,1'b0,1'b1,1'b0, H-1,  1'b0, 5},   // R5 width
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b1, 5},
        '{1'b0,1'b0,1'b1,1'b0, WD-1, 1'b1, 6},   // R6 repeat
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b0, 6},
        '{1'b0,1'b0,1'b1,1'b0, H-1,  1'b0, 6},
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b1, 6},
        '{1'b0,1'b0,1'b1,1'b1, WD+2, 1'b1, 3},   // R3 rising edge restart
        '{1'b0,1'b0,1'b1,1'b1, 1,    1'b0, 3},
        '{1'b0,1'b0,1'b1,1'b1, H-1,  1'b0, 5},
        '{1'b0,1'b0,1'b1,1'b1, 1,    1'b1, 5},
        '{1'b0,1'b0,1'b1,1'b0, WD+2, 1'b1, 3},   // R3 falling edge restart
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b0, 3},
        '{1'b0,1'b0,1'b1,1'b0, H-1,  1'b0, 5},
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b1, 5},
        '{1'b0,1'b0,1'b0,1'b0, 3*WD, 1'b1, 7},   // R7 disabled
        '{1'b0,1'b0,1'b1,1'b0, WD-1, 1'b1, 7},   // R7 full period after enable
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b0, 7},
        '{1'b0,1'b0,1'b1,1'b0, H-1,  1'b0, 11},  // R11
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b1, 11},
        '{1'b0,1'b1,1'b1,1'b0, 0,    1'b0, 8},   // R8 immediate
        '{1'b0,1'b1,1'b1,1'b0, 3*WD, 1'b0, 8},   // R8 held, no pulses
        '{1'b0,1'b0,1'b1,1'b0, H-1,  1'b0, 8},
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b1, 8},
        '{1'b0,1'b0,1'b1,1'b0, WD-1, 1'b1, 8},
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b0, 8},
        '{1'b0,1'b0,1'b1,1'b0, H-1,  1'b0, 8},
        '{1'b0,1'b0,1'b1,1'b0, 1,    1'b1, 8}
    };

    // Every check also covers R9 (reset_p is the inverse of reset_n).
    task automatic check(input logic exp_n, input int req);
        checks++;
        if (reset_n !== exp_n || reset_p !== ~exp_n) begin
            fails++;
            $display("FAIL R%0d (and R9) at %0t: reset_n=%b reset_p=%b expected reset_n=%b reset_p=%b",
                     req, $time, reset_n, reset_p, exp_n, ~exp_n);
        end
    endtask

    task automatic run_step(input step_t s);
        supply_low  = s.sl;
        backup_mode = s.bk;
        wd_enable   = s.en;
        wd_strobe   = s.sb;
        if (s.n == 0) #2;
        else begin
            repeat (s.n) @(posedge clk);
            @(negedge clk);
        end
        check(s.exp_n, s.req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: run hung, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(1'b0, 10);
        rst = 1'b0;

        for (int i = 0; i < NS; i++) run_step(STEPS[i]);

        // R11: supply dip mid-count restarts the watchdog from zero after release
        run_step('{1'b0,1'b0,1'b1,1'b0, 10,   1'b1, 11});
        run_step('{1'b1,1'b0,1'b1,1'b0, 1,    1'b0, 1});
        run_step('{1'b0,1'b0,1'b1,1'b0, H-1,  1'b0, 2});
        run_step('{1'b0,1'b0,1'b1,1'b0, 1,    1'b1, 2});
        run_step('{1'b0,1'b0,1'b1,1'b0, WD-1, 1'b1, 11});
        run_step('{1'b0,1'b0,1'b1,1'b0, 1,    1'b0, 11});
        run_step('{1'b0,1'b0,1'b0,1'b0, H,    1'b1, 5});

        // R10: synchronous reset mid-run, then full hold
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(1'b0, 10);
        rst = 1'b0;
        run_step('{1'b0,1'b0,1'b0,1'b0, H-1, 1'b0, 10});
        run_step('{1'b0,1'b0,1'b0,1'b0, 1,   1'b1, 10});

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule